// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block holds the programmable transfer state of one legacy-style DMA channel. It keeps a 16-bit address and a 16-bit transfer count, each as a base copy and a current copy. Software reaches both through an 8-bit register port. A single internal byte pointer flip-flop decides whether an access touches the low or the high byte. Software can clear the pointer with a command so that the next access lands on the low byte.

Each transfer strobe from the channel's bus logic moves the current address one step up or down and lowers the current count by one. The current count steps from zero to all ones on the last transfer, so a programmed value of N gives N+1 transfers. On that step the block pulses terminal count. If autoinitialize is set, the current registers are then refilled from their base copies and the channel keeps running. If it is not set, the channel stops and ignores strobes until its count is written again.

The current address is joined with an external page byte to form a 24-bit bus address. A parameter selects a byte channel or a word channel. A word channel counts 16-bit words and presents the address shifted left by one.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the byte pointer selects the low byte, the channel is not armed, both current registers read zero and `tc` is low.
- R2: Every cycle with `wr_en` or `rd_en` high toggles the byte pointer (0 = low byte `[7:0]`, 1 = high byte `[15:8]`). `clr_ptr` sets it to the low byte and takes priority over the toggle.
- R3: A write with `reg_sel`=0 loads the addressed byte of both the base and the current address. A write with `reg_sel`=1 does the same for the count and arms the channel. A read returns the addressed byte of the current register.
- R4: An accepted strobe (`xfer` high while armed, with no write in that cycle) increments the current address when `dir_down`=0 and decrements it when `dir_down`=1, wrapping modulo 2^16.
- R5: An accepted strobe decrements the current count. `tc` is high in the same cycle as the strobe exactly when the count was 0000h, so a programmed count N yields N+1 strobes and one `tc` pulse.
- R6: If `auto_init` is 1 on the strobe that raises `tc`, the current address and count are reloaded from their base copies, and the channel stays armed.
- R7: If `auto_init` is 0 on that strobe, the count is left at FFFFh and the channel disarms. Later strobes change neither the address nor the count and raise no `tc` until the count register is written.
- R8: With `WORD_MODE`=0 the output address is {page[7:0], current_address[15:0]}.
- R9: With `WORD_MODE`=1 the output address is {page[7:1], current_address[15:0], 0}, and page bit 0 has no effect.
- R10: `mclr` returns the byte pointer to the low byte and disarms the channel. Register contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mclr | input | 1 | Master clear command strobe |
| clr_ptr | input | 1 | Clear byte pointer command strobe |
| reg_sel | input | 1 | 0 selects the address register, 1 selects the count register |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte of the selected current register |
| dir_down | input | 1 | 1 decrements the address per transfer, 0 increments it |
| auto_init | input | 1 | Reload from base copies on terminal count |
| xfer | input | 1 | Transfer done strobe |
| page | input | 8 | Page byte for the upper address bits |
| tc | output | 1 | Terminal count pulse |
| addr_out | output | 24 | Bus transfer address |

## Verification
The hardest state to reach from the ports is the channel after terminal count. There the count has wrapped to FFFFh and, depending on `auto_init`, the channel is either disarmed or refilled from the base copies. Another hard case is a pointer left on the high byte by a lone read. The bench sweeps the programmed count from 0 to 4 in both directions, using two starting addresses, one of them next to the 16-bit wrap. It counts strobes up to the wrap, then sends extra strobes to show they are ignored. A separate sequence leaves the pointer on the high byte with a single read and then checks that a write and a master clear land where the pointer rules require.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
   localparam int unsigned BYTE_BITS = 8;

   typedef enum logic {
      SEL_ADDR = 1'b0,
      SEL_CNT  = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic toggle,
   output logic hi_sel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hi_sel <= 1'b0;
      else if (clear)  hi_sel <= 1'b0;
      else if (toggle) hi_sel <= ~hi_sel;
   end

   p_ptr_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (toggle && !clear) |=> (hi_sel != $past(hi_sel)));
   p_ptr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !hi_sel);
endmodule

// File: rtl/dma_reg_pair.sv
module dma_reg_pair #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              reload,
   input  logic              step,
   input  logic              step_down,
   output logic [WIDTH-1:0]  cur
);
   localparam int unsigned LO_TOP = BYTE_W - 1;

   if (WIDTH != 2 * BYTE_W) begin : g_bad_width
      $error("dma_reg_pair: WIDTH must be two bytes");
   end

   logic [WIDTH-1:0] base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base <= '0;
         cur  <= '0;
      end else if (wr_lo) begin
         base[LO_TOP:0] <= wdata;
         cur[LO_TOP:0]  <= wdata;
      end else if (wr_hi) begin
         base[WIDTH-1:BYTE_W] <= wdata;
         cur[WIDTH-1:BYTE_W]  <= wdata;
      end else if (reload) begin
         cur <= base;
      end else if (step) begin
         cur <= step_down ? cur - 1'b1 : cur + 1'b1;
      end
   end

   p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && !wr_lo && !wr_hi) |=> (cur == base));
   p_base_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_lo && !wr_hi) |=> $stable(base));
endmodule

// File: rtl/dma_addr_form.sv
module dma_addr_form #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned PAGE_W    = 8,
   parameter bit          WORD_MODE = 1'b0
) (
   input  logic [PAGE_W-1:0]        page,
   input  logic [ADDR_W-1:0]        cur_addr,
   output logic [ADDR_W+PAGE_W-1:0] bus_addr
);
   if (PAGE_W < 2) begin : g_bad_page
      $error("dma_addr_form: PAGE_W must be at least 2");
   end

   if (WORD_MODE) begin : g_word
      logic unused_pg0;
      assign unused_pg0 = page[0];
      assign bus_addr   = {page[PAGE_W-1:1], cur_addr, 1'b0};
   end else begin : g_byte
      assign bus_addr = {page, cur_addr};
   end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned PAGE_W    = 8,
   parameter bit          WORD_MODE = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mclr,
   input  logic                     clr_ptr,
   input  logic                     reg_sel,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [7:0]               wdata,
   output logic [7:0]               rdata,
   input  logic                     dir_down,
   input  logic                     auto_init,
   input  logic                     xfer,
   input  logic [PAGE_W-1:0]        page,
   output logic                     tc,
   output logic [ADDR_W+PAGE_W-1:0] addr_out
);
   import dma_chan_pkg::*;

   localparam int unsigned BW = BYTE_BITS;

   if (ADDR_W != 2 * BW) begin : g_bad_addr
      $error("dma_chan_engine: ADDR_W must be two bytes");
   end

   logic          hi_sel, armed;
   logic [ADDR_W-1:0] addr_cur, cnt_cur, sel_val;
   logic          wr_a_lo, wr_a_hi, wr_c_lo, wr_c_hi;
   logic          step_ok, reload, step;

   dma_byte_ptr u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clr_ptr | mclr),
      .toggle(wr_en | rd_en),
      .hi_sel(hi_sel)
   );

   assign wr_a_lo = wr_en && (reg_sel == SEL_ADDR) && !hi_sel;
   assign wr_a_hi = wr_en && (reg_sel == SEL_ADDR) &&  hi_sel;
   assign wr_c_lo = wr_en && (reg_sel == SEL_CNT)  && !hi_sel;
   assign wr_c_hi = wr_en && (reg_sel == SEL_CNT)  &&  hi_sel;

   assign step_ok = xfer && armed && !wr_en;
   assign tc      = step_ok && (cnt_cur == '0);
   assign reload  = tc && auto_init;
   assign step    = step_ok && !reload;

   dma_reg_pair #(.WIDTH(ADDR_W), .BYTE_W(BW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (wr_a_lo),
      .wr_hi    (wr_a_hi),
      .wdata    (wdata),
      .reload   (reload),
      .step     (step),
      .step_down(dir_down),
      .cur      (addr_cur)
   );

   dma_reg_pair #(.WIDTH(ADDR_W), .BYTE_W(BW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (wr_c_lo),
      .wr_hi    (wr_c_hi),
      .wdata    (wdata),
      .reload   (reload),
      .step     (step),
      .step_down(1'b1),
      .cur      (cnt_cur)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               armed <= 1'b0;
      else if (mclr)                            armed <= 1'b0;
      else if (wr_en && (reg_sel == SEL_CNT))   armed <= 1'b1;
      else if (tc && !auto_init)                armed <= 1'b0;
   end

   assign sel_val = (reg_sel == SEL_CNT) ? cnt_cur : addr_cur;
   assign rdata   = hi_sel ? sel_val[ADDR_W-1:BW] : sel_val[BW-1:0];

   dma_addr_form #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WORD_MODE(WORD_MODE)) u_form (
      .page    (page),
      .cur_addr(addr_cur),
      .bus_addr(addr_out)
   );

   p_tc_needs_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> xfer);
   p_wrap_ffff_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && !auto_init) |=> (cnt_cur == '1 && !armed));
   p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr_en) |=> (cnt_cur == ADDR_W'($past(cnt_cur) - 1'b1)));
   p_addr_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !dir_down) |=> (addr_cur == ADDR_W'($past(addr_cur) + 1'b1)));
   p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !wr_en) |=> ($stable(addr_cur) && $stable(cnt_cur)));
   p_mclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mclr |=> (!armed && !hi_sel));
endmodule

// File: tb/dma_chan_engine_test.sv
module dma_chan_engine_test;
   logic clk = 1'b0, rst_n = 1'b0;
   logic mclr = 0, clr_ptr = 0, reg_sel = 0, wr_en = 0, rd_en = 0;
   logic [7:0] wdata = 0, page = 8'hAB;
   logic dir_down = 0, auto_init = 0, xfer = 0;
   logic [7:0] rdata, rdata_w;
   logic tc, tc_w;
   logic [23:0] addr_out, addr_out_w;
   int errors = 0, checks = 0;

   always #5 clk = ~clk;

   dma_chan_engine #(.WORD_MODE(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .mclr(mclr), .clr_ptr(clr_ptr), .reg_sel(reg_sel),
      .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .dir_down(dir_down),
      .auto_init(auto_init), .xfer(xfer), .page(page), .tc(tc), .addr_out(addr_out));

   dma_chan_engine #(.WORD_MODE(1'b1)) uut_w (
      .clk(clk), .rst_n(rst_n), .mclr(mclr), .clr_ptr(clr_ptr), .reg_sel(reg_sel),
      .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata_w), .dir_down(dir_down),
      .auto_init(auto_init), .xfer(xfer), .page(page), .tc(tc_w), .addr_out(addr_out_w));

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic wr16(input logic sel, input logic [15:0] v);
      @(negedge clk) clr_ptr = 1;
      @(negedge clk) clr_ptr = 0; wr_en = 1; reg_sel = sel; wdata = v[7:0];
      @(negedge clk) wdata = v[15:8];
      @(negedge clk) wr_en = 0;
   endtask

   task automatic rd16(input logic sel, output logic [15:0] v);
      @(negedge clk) clr_ptr = 1;
      @(negedge clk) clr_ptr = 0; rd_en = 1; reg_sel = sel;
      #1 v[7:0] = rdata;
      @(negedge clk) #1 v[15:8] = rdata;
      @(negedge clk) rd_en = 0;
   endtask

   task automatic strobe(output logic seen);
      @(negedge clk) xfer = 1;
      #1 seen = tc;
      @(negedge clk) xfer = 0;
   endtask

   function automatic logic [23:0] word_addr(input logic [7:0] pg, input logic [15:0] a);
      return ({16'h0, pg} & 24'hFE) * 24'h10000 + {8'h0, a} * 24'd2;
   endfunction

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] v, exp_a;
      logic seen;
      int tcs;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      #1 check("R1 tc", tc, 0);
      check("R1 rdata", rdata, 0);
      check("R1 addr_out", addr_out, 24'hAB0000);
      strobe(seen);
      check("R1 unarmed strobe tc", seen, 0);
      rd16(0, v); check("R1 addr zero", v, 0);

      // R3 programming and readback, R8/R9 address forming
      wr16(0, 16'h1234); wr16(1, 16'h0005);
      rd16(0, v); check("R3 addr readback", v, 16'h1234);
      rd16(1, v); check("R3 count readback", v, 16'h0005);
      #1 check("R8 byte addr", addr_out, 24'hAB1234);
      check("R9 word addr", addr_out_w, word_addr(8'hAB, 16'h1234));
      page = 8'hAA; #1 check("R9 page bit0 ignored", addr_out_w, word_addr(8'hAB, 16'h1234));
      page = 8'hAB;

      // R2 lone read leaves pointer high; write hits high byte
      wr16(0, 16'h3412);
      @(negedge clk) clr_ptr = 1;
      @(negedge clk) clr_ptr = 0; rd_en = 1; reg_sel = 0;
      @(negedge clk) rd_en = 0; wr_en = 1; wdata = 8'h77;
      @(negedge clk) wr_en = 0;
      rd16(0, v); check("R2 read toggles pointer", v, 16'h7712);

      // R10 master clear resets pointer and disarms
      wr16(1, 16'h0003);
      @(negedge clk) rd_en = 1; reg_sel = 0;
      @(negedge clk) rd_en = 0; mclr = 1;
      @(negedge clk) mclr = 0; wr_en = 1; reg_sel = 0; wdata = 8'h55;
      @(negedge clk) wr_en = 0;
      rd16(0, v); check("R10 pointer low after mclr", v, 16'h7755);
      strobe(seen); check("R10 disarmed tc", seen, 0);
      rd16(0, v); check("R10 disarmed addr", v, 16'h7755);

      // R4/R5/R7 sweep
      for (int base_i = 0; base_i < 2; base_i++) begin
         for (int d = 0; d < 2; d++) begin
            for (int n = 0; n < 5; n++) begin
               logic [15:0] a0;
               a0 = (base_i == 0) ? 16'h0010 : (d == 0 ? 16'hFFFE : 16'h0001);
               dir_down = d[0]; auto_init = 0;
               wr16(0, a0); wr16(1, 16'(n));
               tcs = 0;
               for (int k = 0; k <= n; k++) begin
                  strobe(seen);
                  if (seen) tcs++;
                  check(k == n ? "R5 tc on last" : "R5 no early tc", seen, (k == n));
               end
               check("R5 one tc pulse", tcs, 1);
               exp_a = d ? a0 - 16'(n + 1) : a0 + 16'(n + 1);
               rd16(0, v); check("R4 address after run", v, exp_a);
               rd16(1, v); check("R7 count ffff", v, 16'hFFFF);
               #1 check("R8 byte addr", addr_out, {page, exp_a});
               check("R9 word addr", addr_out_w, word_addr(page, exp_a));
               strobe(seen); check("R7 extra strobe tc", seen, 0);
               rd16(0, v); check("R7 addr held", v, exp_a);
               rd16(1, v); check("R7 count held", v, 16'hFFFF);
            end
         end
      end

      // R6 autoinitialize
      dir_down = 0; auto_init = 1;
      wr16(0, 16'h0100); wr16(1, 16'h0002);
      strobe(seen); check("R6 first no tc", seen, 0);
      rd16(0, v); check("R4 mid addr", v, 16'h0101);
      rd16(1, v); check("R5 mid count", v, 16'h0001);
      strobe(seen); strobe(seen); check("R6 tc round 1", seen, 1);
      rd16(0, v); check("R6 addr reload", v, 16'h0100);
      rd16(1, v); check("R6 count reload", v, 16'h0002);
      tcs = 0;
      for (int k = 0; k < 3; k++) begin strobe(seen); if (seen) tcs++; end
      check("R6 stays armed tc round 2", tcs, 1);
      rd16(0, v); check("R6 addr reload 2", v, 16'h0100);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule